// File: doc/BRIEF.md
# Delimited Infrared Packet Decoder

This block turns a demodulated infrared light level, sampled once per chip, into button presses from a handheld clicker. Each data bit takes three chips: a low guard chip, a high guard chip, and then the data chip itself. On the line, a one therefore shows as a high of double width and a zero as a high of single width. A packet has 36 bits and is sent most significant bit first. It holds a 4-bit button code, a 24-bit transmitter identifier and an 8-bit checksum.

Every press sends two bursts, separated by a quiet gap. The second burst must carry the bitwise complement of the first. The decoder keeps the first burst and checks its checksum. When the complemented second burst arrives, the decoder either publishes the button code and identifier with a one-cycle valid strobe, or raises a one-cycle error strobe. A chip strobe input marks the clock cycles in which the light level is a fresh chip sample. At the nominal rate of about 2000 chips per second, one chip lasts about 0.5 ms.

Top module: `ir_burst_decoder`

## Requirements
- R1: After reset, `btn_code` and `xmit_id` are zero and neither `pkt_valid` nor `pkt_err` is high.
- R2: While the decoder is hunting, a packet starts on the first high chip that follows a low chip. That high chip is the high guard chip of bit 0, and the next chip carries the data of bit 0. After that, each bit is low guard, high guard, data. The 36 bits arrive MSB first: button code in packet bits 35..32, identifier in 31..8, checksum in 7..0.
- R3: The first burst is accepted only if its checksum field equals the sum, modulo 256, of the zero-extended button code and the three identifier bytes. A press whose first burst fails this test ends in `pkt_err`, and `pkt_valid` does not rise.
- R4: The press is accepted only if all 36 bits of the second burst equal the complement of the first. Any mismatch gives `pkt_err`.
- R5: When a press is accepted, `pkt_valid` is high for exactly the one cycle after the clock edge that samples the last data chip of the second burst. `btn_code` and `xmit_id` take the new values in that same cycle and hold them until the next accepted press.
- R6: A high chip in the low guard slot of a bit is a framing error. `pkt_err` pulses, and any partial or stored burst is discarded.
- R7: A low chip in the high guard slot stalls the decoder. If a high chip then arrives while the run of consecutive low chips is at most 4, that is a framing error and `pkt_err` pulses.
- R8: If the run of consecutive low chips in a stalled packet reaches 5, the decoder drops the packet silently, without `pkt_err`, and returns to hunting.
- R9: After a first burst, the second must start within 40 chips. The gap counts the low chips between the last data chip and the start chip. A start chip that arrives after 39 gap chips is accepted. A 40th gap chip discards the stored burst silently.
- R10: `pkt_valid` and `pkt_err` are never high together, and each strobe lasts a single cycle.
- R11: `ir_level` is ignored in any cycle where `chip_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_stb | input | 1 | High for one cycle per chip sample |
| ir_level | input | 1 | Demodulated light level (1 = light on) |
| btn_code | output | 4 | Button code of the last accepted press |
| xmit_id | output | 24 | Transmitter identifier of the last accepted press |
| pkt_valid | output | 1 | One-cycle strobe: press accepted |
| pkt_err | output | 1 | One-cycle strobe: checksum, complement or framing failure |

## Verification
Two events can land on the same chip: expiry of the gap timer and the start of the second burst. The start must win. The bench provokes this by placing the second burst's start chip directly after 39 low gap chips, which is exactly the chip where a 40th gap chip would have expired the stored burst. It then repeats the press with 40 gap chips. The first case must end in a `pkt_valid` strobe. In the second case, the late burst becomes a new first burst and no strobe of either kind may appear, which the bench judges against a behavioural model compared on every clock.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

    localparam int DEF_BTN_W     = 4;
    localparam int DEF_ID_W      = 24;
    localparam int DEF_CK_W      = 8;
    localparam int DEF_IDLE_CHIP = 4;
    localparam int DEF_GAP_CHIP  = 40;

    // chip-slot position inside a bit
    typedef enum logic [2:0] {
        FR_HUNT,
        FR_GUARD_LO,
        FR_GUARD_HI,
        FR_DATA,
        FR_STALL
    } frm_state_e;

    // burst pairing phase
    typedef enum logic [1:0] {
        PV_FIRST,
        PV_GAP,
        PV_SECOND
    } pair_state_e;

endpackage

// File: rtl/irpd_framer.sv
module irpd_framer
    import irpd_pkg::*;
#(
    parameter int PKT_W     = 36,
    parameter int IDLE_CHIP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_stb,
    input  logic chip_val,
    output logic bit_vld,
    output logic bit_val,
    output logic pkt_start,
    output logic pkt_last,
    output logic frame_err,
    output logic idle_abort
);

    localparam int LRW = $clog2(IDLE_CHIP + 2);
    localparam int CW  = $clog2(PKT_W + 1);
    localparam logic [LRW-1:0] LR_MAX   = LRW'(IDLE_CHIP + 1);
    localparam logic [CW-1:0]  LAST_BIT = CW'(PKT_W - 1);

    typedef struct packed {
        frm_state_e     state;
        logic           prev;
        logic [LRW-1:0] lowrun;
        logic [CW-1:0]  bitcnt;
    } fr_t;

    fr_t fr_q, fr_d;

    always_comb begin
        fr_d       = fr_q;
        bit_vld    = 1'b0;
        bit_val    = 1'b0;
        pkt_start  = 1'b0;
        pkt_last   = 1'b0;
        frame_err  = 1'b0;
        idle_abort = 1'b0;
        if (chip_stb) begin
            fr_d.prev = chip_val;
            if (chip_val) begin
                fr_d.lowrun = '0;
            end else if (fr_q.lowrun != LR_MAX) begin
                fr_d.lowrun = fr_q.lowrun + 1'b1;
            end
            case (fr_q.state)
                FR_HUNT: begin
                    if (chip_val && !fr_q.prev) begin
                        pkt_start   = 1'b1;
                        fr_d.state  = FR_DATA;
                        fr_d.bitcnt = '0;
                    end
                end
                FR_DATA: begin
                    bit_vld = 1'b1;
                    bit_val = chip_val;
                    if (fr_q.bitcnt == LAST_BIT) begin
                        pkt_last   = 1'b1;
                        fr_d.state = FR_HUNT;
                    end else begin
                        fr_d.bitcnt = fr_q.bitcnt + 1'b1;
                        fr_d.state  = FR_GUARD_LO;
                    end
                end
                FR_GUARD_LO: begin
                    if (chip_val) begin
                        frame_err  = 1'b1;
                        fr_d.state = FR_HUNT;
                    end else begin
                        fr_d.state = FR_GUARD_HI;
                    end
                end
                FR_GUARD_HI: begin
                    fr_d.state = chip_val ? FR_DATA : FR_STALL;
                end
                FR_STALL: begin
                    if (chip_val) begin
                        frame_err  = 1'b1;
                        fr_d.state = FR_HUNT;
                    end else if (fr_d.lowrun == LR_MAX) begin
                        idle_abort = 1'b1;
                        fr_d.state = FR_HUNT;
                    end
                end
                default: fr_d.state = FR_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q.state  <= FR_HUNT;
            fr_q.prev   <= 1'b1;
            fr_q.lowrun <= '0;
            fr_q.bitcnt <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    AST_STALL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.state == FR_STALL) |-> !bit_vld);  // R8
    AST_ONE_FRAME_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_err, idle_abort, pkt_last, pkt_start}));  // R6
    AST_QUIET_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_stb |=> $stable(fr_q.state));  // R11

endmodule

// File: rtl/irpd_shift.sv
module irpd_shift #(
    parameter int PKT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_vld,
    input  logic             bit_val,
    output logic [PKT_W-1:0] word_next
);

    typedef struct packed {
        logic [PKT_W-1:0] word;
    } sh_t;

    sh_t sh_q, sh_d;

    always_comb begin
        sh_d      = sh_q;
        word_next = sh_q.word;
        if (bit_vld) begin
            word_next = {sh_q.word[PKT_W-2:0], bit_val};
        end
        if (clear) begin
            sh_d.word = '0;
        end else begin
            sh_d.word = word_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.word <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    AST_CLEAR_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && bit_vld));  // R2

endmodule

// File: rtl/irpd_verify.sv
module irpd_verify
    import irpd_pkg::*;
#(
    parameter int BTN_W    = 4,
    parameter int ID_W     = 24,
    parameter int CK_W     = 8,
    parameter int GAP_CHIP = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chip_stb,
    input  logic                          pkt_start,
    input  logic                          pkt_last,
    input  logic                          frame_err,
    input  logic                          idle_abort,
    input  logic [BTN_W+ID_W+CK_W-1:0]    word_next,
    output logic [BTN_W-1:0]              btn_code,
    output logic [ID_W-1:0]               xmit_id,
    output logic                          pkt_valid,
    output logic                          pkt_err
);

    localparam int PKT_W  = BTN_W + ID_W + CK_W;
    localparam int NCHUNK = ID_W / CK_W;
    localparam int GW     = $clog2(GAP_CHIP + 1);
    localparam logic [GW-1:0] GAP_END = GW'(GAP_CHIP - 1);

    typedef struct packed {
        pair_state_e       state;
        logic [PKT_W-1:0]  first;
        logic [GW-1:0]     gap;
        logic [BTN_W-1:0]  btn;
        logic [ID_W-1:0]   id;
        logic              valid;
        logic              err;
    } pv_t;

    pv_t pv_q, pv_d;

    function automatic logic sum_ok(input logic [PKT_W-1:0] w);
        logic [CK_W-1:0] s;
        s = CK_W'(w[PKT_W-1 -: BTN_W]);
        for (int i = 0; i < NCHUNK; i++) begin
            s = s + w[CK_W + i*CK_W +: CK_W];
        end
        return s == w[CK_W-1:0];
    endfunction

    always_comb begin
        pv_d       = pv_q;
        pv_d.valid = 1'b0;
        pv_d.err   = 1'b0;
        if (frame_err) begin
            pv_d.err   = 1'b1;
            pv_d.state = PV_FIRST;
        end else if (idle_abort) begin
            pv_d.state = PV_FIRST;
        end else if (pkt_last) begin
            if (pv_q.state == PV_SECOND) begin
                if (sum_ok(pv_q.first) && (word_next == ~pv_q.first)) begin
                    pv_d.valid = 1'b1;
                    pv_d.btn   = pv_q.first[PKT_W-1 -: BTN_W];
                    pv_d.id    = pv_q.first[CK_W +: ID_W];
                end else begin
                    pv_d.err   = 1'b1;
                end
                pv_d.state = PV_FIRST;
            end else begin
                pv_d.first = word_next;
                pv_d.gap   = '0;
                pv_d.state = PV_GAP;
            end
        end else if ((pv_q.state == PV_GAP) && chip_stb) begin
            if (pkt_start) begin
                pv_d.state = PV_SECOND;
            end else if (pv_q.gap == GAP_END) begin
                pv_d.gap   = '0;
                pv_d.state = PV_FIRST;
            end else begin
                pv_d.gap   = pv_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q.state <= PV_FIRST;
            pv_q.first <= '0;
            pv_q.gap   <= '0;
            pv_q.btn   <= '0;
            pv_q.id    <= '0;
            pv_q.valid <= 1'b0;
            pv_q.err   <= 1'b0;
        end else begin
            pv_q <= pv_d;
        end
    end

    assign btn_code  = pv_q.btn;
    assign xmit_id   = pv_q.id;
    assign pkt_valid = pv_q.valid;
    assign pkt_err   = pv_q.err;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && pkt_err));  // R10
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);  // R5
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |=> !pkt_err);  // R10
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> ($stable(xmit_id) && $stable(btn_code)));  // R5
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q.gap < GW'(GAP_CHIP));  // R9

endmodule

// File: rtl/ir_burst_decoder.sv
module ir_burst_decoder
    import irpd_pkg::*;
#(
    parameter int BTN_W     = DEF_BTN_W,
    parameter int ID_W      = DEF_ID_W,
    parameter int CK_W      = DEF_CK_W,
    parameter int IDLE_CHIP = DEF_IDLE_CHIP,
    parameter int GAP_CHIP  = DEF_GAP_CHIP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_stb,
    input  logic              ir_level,
    output logic [BTN_W-1:0]  btn_code,
    output logic [ID_W-1:0]   xmit_id,
    output logic              pkt_valid,
    output logic              pkt_err
);

    localparam int PKT_W = BTN_W + ID_W + CK_W;

    logic             bit_vld;
    logic             bit_val;
    logic             pkt_start;
    logic             pkt_last;
    logic             frame_err;
    logic             idle_abort;
    logic [PKT_W-1:0] word_next;

    irpd_framer #(
        .PKT_W     (PKT_W),
        .IDLE_CHIP (IDLE_CHIP)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_stb   (chip_stb),
        .chip_val   (ir_level),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .pkt_start  (pkt_start),
        .pkt_last   (pkt_last),
        .frame_err  (frame_err),
        .idle_abort (idle_abort)
    );

    irpd_shift #(
        .PKT_W (PKT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pkt_start),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .word_next (word_next)
    );

    irpd_verify #(
        .BTN_W    (BTN_W),
        .ID_W     (ID_W),
        .CK_W     (CK_W),
        .GAP_CHIP (GAP_CHIP)
    ) u_verify (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_stb   (chip_stb),
        .pkt_start  (pkt_start),
        .pkt_last   (pkt_last),
        .frame_err  (frame_err),
        .idle_abort (idle_abort),
        .word_next  (word_next),
        .btn_code   (btn_code),
        .xmit_id    (xmit_id),
        .pkt_valid  (pkt_valid),
        .pkt_err    (pkt_err)
    );

    AST_ERR_NEEDS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> $past(chip_stb));  // R6

endmodule

// File: tb/ir_burst_decoder_bench.sv
module ir_burst_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_stb = 1'b0;
    logic        ir_level = 1'b0;
    logic [3:0]  btn_code;
    logic [23:0] xmit_id;
    logic        pkt_valid;
    logic        pkt_err;

    always #4 clk = ~clk;   // 125 MHz

    ir_burst_decoder u_ir_burst_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_stb  (chip_stb),
        .ir_level  (ir_level),
        .btn_code  (btn_code),
        .xmit_id   (xmit_id),
        .pkt_valid (pkt_valid),
        .pkt_err   (pkt_err)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int seen_valid = 0;
    int seen_err = 0;
    bit finished = 0;

    // behavioural reference model
    int          m_mode;     // 0 hunt, 1 receiving, 2 stalled
    int          m_slot;     // 0 low guard, 1 high guard, 2 data
    int          m_lowrun;
    int          m_nbits;
    bit          m_prev;
    logic [35:0] m_word;
    logic [35:0] m_first;
    bit          m_have1;
    bit          m_rx2;
    int          m_gap;
    bit          exp_valid;
    bit          exp_err;
    logic [3:0]  exp_btn;
    logic [23:0] exp_id;

    task automatic model_reset();
        m_mode = 0; m_slot = 0; m_lowrun = 0; m_nbits = 0; m_prev = 1;
        m_word = '0; m_first = '0; m_have1 = 0; m_rx2 = 0; m_gap = 0;
        exp_valid = 0; exp_err = 0; exp_btn = '0; exp_id = '0;
    endtask

    task automatic model_step(input bit c);
        bit started, done, ferr, abrt;
        int sum;
        started = 0; done = 0; ferr = 0; abrt = 0;
        m_lowrun = c ? 0 : m_lowrun + 1;
        if (m_mode == 0) begin
            if (c && !m_prev) begin
                started = 1; m_mode = 1; m_slot = 2; m_nbits = 0; m_word = '0;
            end
        end else if (m_mode == 1) begin
            if (m_slot == 2) begin
                m_word = {m_word[34:0], c};
                m_nbits++;
                if (m_nbits == 36) begin done = 1; m_mode = 0; end
                else m_slot = 0;
            end else if (m_slot == 0) begin
                if (c) begin ferr = 1; m_mode = 0; end
                else m_slot = 1;
            end else begin
                if (c) m_slot = 2;
                else m_mode = 2;
            end
        end else begin
            if (c) begin ferr = 1; m_mode = 0; end
            else if (m_lowrun > 4) begin abrt = 1; m_mode = 0; end
        end
        m_prev = c;
        if (ferr) begin
            exp_err = 1; m_have1 = 0; m_rx2 = 0;
        end else if (abrt) begin
            m_have1 = 0; m_rx2 = 0;
        end else if (done) begin
            if (m_rx2) begin
                sum = m_first[35:32] + m_first[31:24] + m_first[23:16] + m_first[15:8];
                if ((sum % 256) == m_first[7:0] && m_word == ~m_first) begin
                    exp_valid = 1; exp_btn = m_first[35:32]; exp_id = m_first[31:8];
                end else begin
                    exp_err = 1;
                end
                m_rx2 = 0; m_have1 = 0;
            end else begin
                m_first = m_word; m_have1 = 1; m_gap = 0;
            end
        end else if (m_have1 && !m_rx2) begin
            if (started) m_rx2 = 1;
            else begin
                m_gap++;
                if (m_gap >= 40) m_have1 = 0;
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) model_reset();
        else begin
            exp_valid = 0;
            exp_err = 0;
            if (chip_stb) model_step(ir_level);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5 pkt_valid", 64'(pkt_valid), 64'(exp_valid));
            chk("R10 pkt_err", 64'(pkt_err), 64'(exp_err));
            chk("R5 btn_code", 64'(btn_code), 64'(exp_btn));
            chk("R5 xmit_id", 64'(xmit_id), 64'(exp_id));
            if (pkt_valid) seen_valid++;
            if (pkt_err) seen_err++;
        end
    end

    // stimulus; between strobes the level is driven inverted (R11)
    task automatic chip(input bit b);
        @(negedge clk);
        ir_level = b; chip_stb = 1'b1;
        @(negedge clk);
        chip_stb = 1'b0; ir_level = ~b;
        repeat (2) @(negedge clk);
    endtask

    task automatic lows(input int n);
        for (int i = 0; i < n; i++) chip(1'b0);
    endtask

    task automatic send_bit(input bit b);
        chip(1'b0); chip(1'b1); chip(b);
    endtask

    task automatic send_pkt(input logic [35:0] w);
        // bit 0: the preceding low serves as its low guard
        chip(1'b1); chip(w[35]);
        for (int i = 34; i >= 0; i--) send_bit(w[i]);
    endtask

    function automatic logic [35:0] mk(input logic [3:0] b, input logic [23:0] id, input int adj);
        int s;
        s = (b + id[23:16] + id[15:8] + id[7:0] + adj) % 256;
        return {b, id, 8'(s)};
    endfunction

    task automatic press(input logic [35:0] w1, input logic [35:0] w2, input int gap);
        lows(6); send_pkt(w1); lows(gap); send_pkt(w2); lows(6);
    endtask

    int v0, e0;

    task automatic mark();
        v0 = seen_valid; e0 = seen_err;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [35:0] w;
        repeat (3) @(negedge clk);
        chk("R1 reset btn_code", 64'(btn_code), 64'h0);
        chk("R1 reset xmit_id", 64'(xmit_id), 64'h0);
        chk("R1 reset strobes", 64'({pkt_valid, pkt_err}), 64'h0);
        rst_n = 1'b1;

        // R2 R5 R11: button A, id 55573, checksum 247
        w = mk(4'h9, 24'h00D915, 0);
        chk("R3 example checksum", 64'(w[7:0]), 64'd247);
        mark(); press(w, ~w, 18);
        chk("R5 valid count A", 64'(seen_valid - v0), 64'd1);
        chk("R2 button A", 64'(btn_code), 64'h9);
        chk("R2 id A", 64'(xmit_id), 64'h00D915);
        chk("R11 no err A", 64'(seen_err - e0), 64'd0);

        // R2: button E, another id with carry in sum
        w = mk(4'hD, 24'hABCDEF, 0);
        mark(); press(w, ~w, 18);
        chk("R2 button E", 64'(btn_code), 64'hD);
        chk("R2 id E", 64'(xmit_id), 64'hABCDEF);

        // R3: bad checksum
        w = mk(4'hB, 24'h123456, 1);
        mark(); press(w, ~w, 18);
        chk("R3 checksum err", 64'(seen_err - e0), 64'd1);
        chk("R3 checksum no valid", 64'(seen_valid - v0), 64'd0);
        chk("R5 id held after reject", 64'(xmit_id), 64'hABCDEF);

        // R4: second burst with one bit not inverted
        w = mk(4'hC, 24'h0F0F0F, 0);
        mark(); press(w, ~w ^ 36'h000010000, 18);
        chk("R4 inverse err", 64'(seen_err - e0), 64'd1);
        chk("R4 inverse no valid", 64'(seen_valid - v0), 64'd0);

        // R6: high in low guard slot
        mark(); lows(6); chip(1'b1); chip(1'b1); send_bit(1'b0); chip(1'b1); lows(8);
        chk("R6 guard-lo err", 64'(seen_err - e0), 64'd1);

        // R7: low high-guard then high after 4 lows
        mark(); lows(6); chip(1'b1); chip(1'b0); chip(1'b0); chip(1'b0); chip(1'b0); chip(1'b1);
        lows(8);
        chk("R7 stall err", 64'(seen_err - e0), 64'd1);

        // R8: five lows in stall -> silent abort, then full press recovers
        mark(); lows(6); chip(1'b1); chip(1'b1); chip(1'b0); chip(1'b0);
        chip(1'b0); chip(1'b0); chip(1'b0); lows(8);
        chk("R8 silent abort", 64'(seen_err - e0), 64'd0);
        w = mk(4'hE, 24'h00AA55, 0);
        mark(); press(w, ~w, 18);
        chk("R8 recovery valid", 64'(seen_valid - v0), 64'd1);
        chk("R8 recovery btn", 64'(btn_code), 64'hE);

        // R9: start on the chip where the gap would expire
        w = mk(4'hA, 24'h3C5A96, 0);
        mark(); press(w, ~w, 39);
        chk("R9 gap 39 valid", 64'(seen_valid - v0), 64'd1);
        chk("R9 gap 39 id", 64'(xmit_id), 64'h3C5A96);
        w = mk(4'h9, 24'h777777, 0);
        mark(); press(w, ~w, 40); lows(45);
        chk("R9 gap 40 no valid", 64'(seen_valid - v0), 64'd0);
        chk("R9 gap 40 no err", 64'(seen_err - e0), 64'd0);
        chk("R10 final strobes low", 64'({pkt_valid, pkt_err}), 64'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule